// File: doc/BRIEF.md
# Golden-versus-faulty response monitor

This block sits beside two copies of a design under test during a fault-emulation run. One copy is fault-free and the other carries fault instrumentation. Every clock the monitor registers a comparison of the two output buses and drives a match flag. The flag stays high while the copies agree and goes low for as long as an injected fault disturbs the observed response.

The fault scheduler reports the number of the fault currently applied and holds a strobe high for the whole slot given to that fault, including any propagation wait. Only one fault is live at a time, so the monitor charges each mismatch to the open slot. For every slot it records whether the fault was seen at the outputs and how many cycles passed between the start of the slot and the first disagreement. It then emits one result record on a valid/ready stream. It also keeps a sticky per-fault detection map and two running counters, slots closed and slots detected. Coverage is the ratio of the two counters.

The result stream follows the usual rules. A record stays valid, with stable fields, until `res_ready_i` is seen high on a clock edge. Records wait in a small queue of `RES_DEPTH` entries. If a slot closes while the queue is full and nothing leaves in the same cycle, that record is discarded, but the counters and the map still take the slot into account. The inputs carry no handshake: both buses are sampled on every edge.

Top module: `fault_response_monitor`

## Requirements
- R1: `match_o` is registered. It is low in the cycle after any cycle in which `golden_i` differs from `faulty_i`, and high in the cycle after the two are equal, whatever the strobe is doing.
- R2: A slot opens in a cycle where `fault_active_i` is high and either no slot is open or `fault_id_i` differs from the open slot's number. Only mismatches seen while the strobe is high count toward that slot. Mismatches seen while the strobe is low are not charged to any fault.
- R3: Latency is the number of cycles from the first strobe cycle of the slot to the first mismatching cycle, and is 0 when the two coincide. Later mismatches in the same slot leave the latency and the detected state unchanged.
- R4: The latency count saturates at 2^LAT_W-1 (255 by default). A detection at or beyond that point reports 255. An undetected slot always reports 255 with the detected bit 0.
- R5: When a slot closes, a record {fault number, detected, latency} is queued. It is visible on the stream two cycles after the first cycle in which the strobe is sampled low or the fault number changes.
- R6: A change of `fault_id_i` while the strobe stays high closes the old slot and opens a new one in the same cycle. The new slot's latency counts from the cycle of the change.
- R7: Bit n of `det_map_o` is set when fault n is detected, and stays set until reset, even if fault n is later applied again without effect.
- R8: `total_count_o` rises by one for every closed slot, and `det_count_o` rises by one for every closed slot that was detected. Both update on the same edge that queues the record.
- R9: While `res_valid_o` is high and `res_ready_i` is low, the record fields stay stable. The queue holds `RES_DEPTH` (default 2) records. A record that closes into a full queue with no pop in the same cycle is dropped, and R8 still counts it.
- R10: Reset clears the counters, the map and the queue, and drives `match_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| golden_i | input | DATA_W | Output bus of the fault-free copy |
| faulty_i | input | DATA_W | Output bus of the instrumented copy |
| fault_id_i | input | $clog2(NUM_FAULTS) | Number of the fault currently scheduled |
| fault_active_i | input | 1 | High for the whole slot of the scheduled fault |
| match_o | output | 1 | Registered equality of the two buses |
| res_valid_o | output | 1 | A result record is offered |
| res_ready_i | input | 1 | Consumer accepts the offered record |
| res_id_o | output | $clog2(NUM_FAULTS) | Fault number of the record |
| res_detected_o | output | 1 | The fault produced a mismatch in its slot |
| res_latency_o | output | LAT_W | Cycles from slot start to first mismatch, saturated |
| det_map_o | output | NUM_FAULTS | Sticky per-fault detection bits |
| total_count_o | output | CNT_W | Slots closed since reset |
| det_count_o | output | CNT_W | Detected slots since reset |

## Verification
The bench places mismatches on the first and on the last strobe cycle of a slot. A design with an off-by-one slot window would miss one of these or report a latency of 1 for a same-cycle hit. It also places a mismatch one cycle after the strobe falls, which a monitor that still charges the old fault would wrongly count. Further tests cover a second mismatch late in a slot, which must not move the recorded latency, and a slot long enough to saturate the latency counter. A back-to-back change of fault number tests whether the old slot is closed and the new one opened together, rather than merged. Holding ready low across three closures fills the queue, so a design that overwrote a queued record or skipped counting a dropped one would be caught.

// File: rtl/fim_pkg.sv
package fim_pkg;

  // What the slot tracker sees on a given edge
  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_OPEN   = 2'd1,
    SLOT_CLOSE  = 2'd2,
    SLOT_SWITCH = 2'd3
  } slot_evt_e;

endpackage

// File: rtl/fim_compare.sv
// Registers the bus comparison together with the scheduler strobe and number,
// so every downstream decision uses values sampled on one edge.
module fim_compare #(
  parameter int DATA_W = 16,
  parameter int ID_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] golden_i,
  input  logic [DATA_W-1:0] faulty_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic              active_i,
  output logic              mism_q_o,
  output logic              active_q_o,
  output logic [ID_W-1:0]   id_q_o,
  output logic              match_o
);

  logic diff;
  assign diff = |(golden_i ^ faulty_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mism_q_o   <= 1'b0;
      active_q_o <= 1'b0;
      id_q_o     <= '0;
    end else begin
      mism_q_o   <= diff;
      active_q_o <= active_i;
      id_q_o     <= id_i;
    end
  end

  assign match_o = ~mism_q_o;

endmodule

// File: rtl/fim_slot_tracker.sv
// Follows one fault slot at a time: detection, latency, map and counters.
module fim_slot_tracker
  import fim_pkg::*;
#(
  parameter int NUM_FAULTS = 64,
  parameter int ID_W       = 6,
  parameter int LAT_W      = 8,
  parameter int CNT_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mism_i,
  input  logic                  active_i,
  input  logic [ID_W-1:0]       id_i,
  output logic                  push_o,
  output logic [ID_W-1:0]       push_id_o,
  output logic                  push_det_o,
  output logic [LAT_W-1:0]      push_lat_o,
  output logic [NUM_FAULTS-1:0] det_map_o,
  output logic [CNT_W-1:0]      total_cnt_o,
  output logic [CNT_W-1:0]      det_cnt_o
);

  localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};

  logic             open_q;
  logic [ID_W-1:0]  cur_id_q;
  logic             det_q;
  logic [LAT_W-1:0] lat_q;
  logic [NUM_FAULTS-1:0] map_q;
  logic [NUM_FAULTS-1:0] map_set;
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] detc_q;

  logic      id_change;
  slot_evt_e evt;
  logic      closing;
  logic      starting;
  logic      running;
  logic      hit_new;
  logic      hit_run;
  logic [LAT_W-1:0] lat_inc;

  assign id_change = open_q && active_i && (id_i != cur_id_q);

  always_comb begin
    if (id_change)                evt = SLOT_SWITCH;
    else if (active_i && !open_q) evt = SLOT_OPEN;
    else if (!active_i && open_q) evt = SLOT_CLOSE;
    else                          evt = SLOT_IDLE;
  end

  assign closing  = (evt == SLOT_CLOSE) || (evt == SLOT_SWITCH);
  assign starting = (evt == SLOT_OPEN)  || (evt == SLOT_SWITCH);
  assign running  = (evt == SLOT_IDLE) && open_q && active_i;
  assign hit_new  = starting && mism_i;
  assign hit_run  = running && !det_q && mism_i;
  assign lat_inc  = (lat_q == LAT_MAX) ? lat_q : lat_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      cur_id_q <= '0;
      det_q    <= 1'b0;
      lat_q    <= '0;
    end else if (starting) begin
      open_q   <= 1'b1;
      cur_id_q <= id_i;
      det_q    <= mism_i;
      lat_q    <= '0;
    end else if (running) begin
      if (!det_q) begin
        lat_q <= lat_inc;
        det_q <= mism_i;
      end
    end else if (!active_i) begin
      open_q <= 1'b0;
    end
  end

  // Sticky detection map, one set term per fault number
  for (genvar gi = 0; gi < NUM_FAULTS; gi++) begin : g_map
    assign map_set[gi] = (hit_new && (id_i == ID_W'(gi))) ||
                         (hit_run && (cur_id_q == ID_W'(gi)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q   <= '0;
      total_q <= '0;
      detc_q  <= '0;
    end else begin
      map_q <= map_q | map_set;
      if (closing) begin
        total_q <= total_q + 1'b1;
        if (det_q) detc_q <= detc_q + 1'b1;
      end
    end
  end

  assign push_o      = closing;
  assign push_id_o   = cur_id_q;
  assign push_det_o  = det_q;
  assign push_lat_o  = det_q ? lat_q : LAT_MAX;
  assign det_map_o   = map_q;
  assign total_cnt_o = total_q;
  assign det_cnt_o   = detc_q;

endmodule

// File: rtl/fim_result_queue.sv
// Small circular queue feeding the result stream; drops on full.
module fim_result_queue #(
  parameter int W     = 15,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q;
  logic [PTR_W-1:0] rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full;
  logic             pop;
  logic             take;

  assign full = (cnt_q == CNT_W'(DEPTH));
  assign pop  = out_valid_o && out_ready_i;
  assign take = push_i && (!full || pop);

  always_ff @(posedge clk) begin
    if (take) mem[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (take) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (take && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !take) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign out_valid_o = (cnt_q != '0);
  assign out_data_o  = mem[rd_q];

endmodule

// File: rtl/fault_response_monitor.sv
module fault_response_monitor #(
  parameter int DATA_W     = 16,
  parameter int NUM_FAULTS = 64,
  parameter int LAT_W      = 8,
  parameter int CNT_W      = 16,
  parameter int RES_DEPTH  = 2,
  localparam int ID_W      = $clog2(NUM_FAULTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DATA_W-1:0]     golden_i,
  input  logic [DATA_W-1:0]     faulty_i,
  input  logic [ID_W-1:0]       fault_id_i,
  input  logic                  fault_active_i,
  output logic                  match_o,
  output logic                  res_valid_o,
  input  logic                  res_ready_i,
  output logic [ID_W-1:0]       res_id_o,
  output logic                  res_detected_o,
  output logic [LAT_W-1:0]      res_latency_o,
  output logic [NUM_FAULTS-1:0] det_map_o,
  output logic [CNT_W-1:0]      total_count_o,
  output logic [CNT_W-1:0]      det_count_o
);

  localparam int REC_W = ID_W + 1 + LAT_W;

  logic             mism_q;
  logic             act_q;
  logic [ID_W-1:0]  id_q;
  logic             push;
  logic [ID_W-1:0]  push_id;
  logic             push_det;
  logic [LAT_W-1:0] push_lat;
  logic [REC_W-1:0] rec_out;

  fim_compare #(.DATA_W(DATA_W), .ID_W(ID_W)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .golden_i(golden_i), .faulty_i(faulty_i),
    .id_i(fault_id_i), .active_i(fault_active_i),
    .mism_q_o(mism_q), .active_q_o(act_q), .id_q_o(id_q),
    .match_o(match_o)
  );

  fim_slot_tracker #(
    .NUM_FAULTS(NUM_FAULTS), .ID_W(ID_W), .LAT_W(LAT_W), .CNT_W(CNT_W)
  ) u_trk (
    .clk(clk), .rst_n(rst_n),
    .mism_i(mism_q), .active_i(act_q), .id_i(id_q),
    .push_o(push), .push_id_o(push_id), .push_det_o(push_det),
    .push_lat_o(push_lat), .det_map_o(det_map_o),
    .total_cnt_o(total_count_o), .det_cnt_o(det_count_o)
  );

  fim_result_queue #(.W(REC_W), .DEPTH(RES_DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n),
    .push_i(push), .push_data_i({push_id, push_det, push_lat}),
    .out_valid_o(res_valid_o), .out_ready_i(res_ready_i),
    .out_data_o(rec_out)
  );

  assign {res_id_o, res_detected_o, res_latency_o} = rec_out;

endmodule

// File: rtl/fault_response_monitor_chk.sv
module fault_response_monitor_chk #(
  parameter int DATA_W     = 16,
  parameter int NUM_FAULTS = 64,
  parameter int LAT_W      = 8,
  parameter int CNT_W      = 16,
  parameter int ID_W       = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [DATA_W-1:0]     golden_i,
  input logic [DATA_W-1:0]     faulty_i,
  input logic                  match_o,
  input logic                  res_valid_o,
  input logic                  res_ready_i,
  input logic [ID_W-1:0]       res_id_o,
  input logic                  res_detected_o,
  input logic [LAT_W-1:0]      res_latency_o,
  input logic [NUM_FAULTS-1:0] det_map_o,
  input logic [CNT_W-1:0]      total_count_o,
  input logic [CNT_W-1:0]      det_count_o
);

  localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};

  // R1
  mismatch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (golden_i != faulty_i) |=> !match_o);

  // R1
  equal_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (golden_i == faulty_i) |=> match_o);

  // R9
  hold_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_id_o) &&
      $stable(res_detected_o) && $stable(res_latency_o)));

  // R4
  undetected_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_detected_o) |-> (res_latency_o == LAT_MAX));

  // R7
  map_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((det_map_o & $past(det_map_o)) == $past(det_map_o)));

  // R8
  total_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((total_count_o == $past(total_count_o)) ||
               (total_count_o == $past(total_count_o) + 1'b1)));

  // R8
  det_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_count_o != $past(det_count_o)) |-> (total_count_o != $past(total_count_o)));

endmodule

bind fault_response_monitor fault_response_monitor_chk #(
  .DATA_W(DATA_W), .NUM_FAULTS(NUM_FAULTS), .LAT_W(LAT_W),
  .CNT_W(CNT_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .golden_i(golden_i), .faulty_i(faulty_i),
  .match_o(match_o), .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
  .res_id_o(res_id_o), .res_detected_o(res_detected_o),
  .res_latency_o(res_latency_o), .det_map_o(det_map_o),
  .total_count_o(total_count_o), .det_count_o(det_count_o)
);

// File: tb/tb_fault_response_monitor.sv
module tb_fault_response_monitor;

  localparam int DATA_W = 16;
  localparam int NF     = 64;
  localparam int LAT_W  = 8;
  localparam int CNT_W  = 16;
  localparam int ID_W   = 6;
  localparam int LMAX   = 255;

  // Vector table: fault, slot length, first and second mismatch offsets
  // (-1 none), expected detected bit, expected latency
  localparam int NV = 6;
  localparam int V_ID   [NV] = '{3, 7, 1, 12, 7, 63};
  localparam int V_LEN  [NV] = '{10, 12, 8, 6, 300, 4};
  localparam int V_OFF  [NV] = '{0, 5, -1, 5, 280, 4};
  localparam int V_OFF2 [NV] = '{-1, 9, -1, -1, -1, -1};
  localparam int V_DET  [NV] = '{1, 1, 0, 1, 1, 0};
  localparam int V_LAT  [NV] = '{0, 5, LMAX, 5, LMAX, LMAX};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DATA_W-1:0] golden = '0;
  logic [DATA_W-1:0] faulty = '0;
  logic [ID_W-1:0]   fid = '0;
  logic              fact = 1'b0;
  logic              ready = 1'b0;
  logic              match_o;
  logic              res_valid;
  logic [ID_W-1:0]   res_id;
  logic              res_det;
  logic [LAT_W-1:0]  res_lat;
  logic [NF-1:0]     det_map;
  logic [CNT_W-1:0]  total_cnt;
  logic [CNT_W-1:0]  det_cnt;

  int checks = 0;
  int fails  = 0;
  int exp_total = 0;
  int exp_det   = 0;
  logic [NF-1:0] exp_map = '0;

  always #2 clk = ~clk;

  fault_response_monitor #(
    .DATA_W(DATA_W), .NUM_FAULTS(NF), .LAT_W(LAT_W), .CNT_W(CNT_W), .RES_DEPTH(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .golden_i(golden), .faulty_i(faulty),
    .fault_id_i(fid), .fault_active_i(fact), .match_o(match_o),
    .res_valid_o(res_valid), .res_ready_i(ready), .res_id_o(res_id),
    .res_detected_o(res_det), .res_latency_o(res_lat), .det_map_o(det_map),
    .total_count_o(total_cnt), .det_count_o(det_cnt)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; checks match_o right after the edge (R1)
  task automatic cyc(input logic act, input int id, input logic [DATA_W-1:0] g, input bit mm);
    @(negedge clk);
    fact   = act;
    fid    = ID_W'(id);
    golden = g;
    faulty = mm ? (g ^ 16'h0100) : g;
    @(posedge clk);
    #1;
    chk(match_o == !mm, "R1 match", 64'(match_o), 64'(!mm));
  endtask

  task automatic check_rec(input string req, input int id, input int det, input int lat);
    chk(res_valid == 1'b1, {req, " valid"}, 64'(res_valid), 64'd1);
    chk(res_id == ID_W'(id), {req, " id"}, 64'(res_id), 64'(id));
    chk(res_det == det[0], {req, " detected"}, 64'(res_det), 64'(det));
    chk(res_lat == LAT_W'(lat), {req, " latency"}, 64'(res_lat), 64'(lat));
  endtask

  task automatic pop_one();
    @(negedge clk);
    ready = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic check_counts(input string req);
    chk(total_cnt == CNT_W'(exp_total), {req, " total"}, 64'(total_cnt), 64'(exp_total));
    chk(det_cnt == CNT_W'(exp_det), {req, " detected count"}, 64'(det_cnt), 64'(exp_det));
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk(match_o == 1'b1, "R10 match", 64'(match_o), 64'd1);
    chk(res_valid == 1'b0, "R10 valid", 64'(res_valid), 64'd0);
    chk(det_map == '0, "R10 map", det_map, 64'd0);
    check_counts("R10");

    // R2: mismatch with no slot open charges nothing
    cyc(1'b0, 5, 16'h1234, 1'b1);
    cyc(1'b0, 5, 16'h1234, 1'b0);
    cyc(1'b0, 5, 16'h1234, 1'b0);
    chk(det_map == '0, "R2 idle mismatch map", det_map, 64'd0);
    chk(res_valid == 1'b0, "R2 idle mismatch record", 64'(res_valid), 64'd0);
    check_counts("R2 idle");

    // Table walk: R2 R3 R4 R5 R7 R8
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < V_LEN[v]; c++)
        cyc(1'b1, V_ID[v], 16'(c * 37 + v * 101), (c == V_OFF[v]) || (c == V_OFF2[v]));
      for (int c = 0; c < 3; c++)
        cyc(1'b0, V_ID[v], 16'(c * 11), (V_LEN[v] + c) == V_OFF[v]);
      exp_total++;
      exp_det += V_DET[v];
      if (V_DET[v] == 1) exp_map[V_ID[v]] = 1'b1;
      check_rec("R3 R4 R5 table", V_ID[v], V_DET[v], V_LAT[v]);
      check_counts("R8 table");
      pop_one();
      chk(res_valid == 1'b0, "R9 popped", 64'(res_valid), 64'd0);
    end
    // R7: fault 7 detected twice, 1 and 63 never
    chk(det_map == exp_map, "R7 map", det_map, exp_map);

    // R6: number changes while the strobe stays high
    for (int c = 0; c < 7; c++)
      cyc(1'b1, (c < 4) ? 20 : 21, 16'(c + 500), c == 2);
    for (int c = 0; c < 3; c++) cyc(1'b0, 21, 16'h0, 1'b0);
    exp_total += 2;
    exp_det   += 1;
    exp_map[20] = 1'b1;
    check_counts("R6");
    check_rec("R6 first", 20, 1, 2);
    pop_one();
    check_rec("R6 second", 21, 0, LMAX);
    pop_one();
    chk(res_valid == 1'b0, "R6 drained", 64'(res_valid), 64'd0);
    chk(det_map == exp_map, "R7 map after switch", det_map, exp_map);

    // R9: three closures into a two-entry queue with ready low
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, 30 + k, 16'h55, 1'b0);
      cyc(1'b1, 30 + k, 16'h56, 1'b0);
      cyc(1'b0, 0, 16'h0, 1'b0);
      cyc(1'b0, 0, 16'h0, 1'b0);
    end
    cyc(1'b0, 0, 16'h0, 1'b0);
    exp_total += 3;
    check_counts("R9 drop still counted");
    check_rec("R9 kept first", 30, 0, LMAX);
    pop_one();
    check_rec("R9 kept second", 31, 0, LMAX);
    pop_one();
    chk(res_valid == 1'b0, "R9 third dropped", 64'(res_valid), 64'd0);

    // R10: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    exp_total = 0;
    exp_det   = 0;
    chk(det_map == '0, "R10 map cleared", det_map, 64'd0);
    chk(match_o == 1'b1, "R10 match after reset", 64'(match_o), 64'd1);
    check_counts("R10 cleared");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule